// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps the time of day as six binary-coded decimal digits: units and tens for seconds, minutes and hours. A one-cycle pulse on the seconds tick input advances the seconds units digit. Each units digit that passes 9 returns to 0 and advances its tens digit. Each field that wraps passes a carry to the next field, so seconds feed minutes and minutes feed hours. The hours field treats its two digits as one value and returns to 00 after 23.

The digits are registered and can drive display decoders directly. Three carry outputs mark the minute, hour and day boundaries. Each one is a one-cycle pulse that rises in the same cycle as the digits showing the wrapped value. A whole carry chain settles within a single update, so 23:59:59 becomes 00:00:00 on one tick. A synchronous master reset clears every digit and every carry output.

Top module: `tod_bcd_chain`

## Requirements
- R1: While reset is high at a clock edge, all six digits become 0 and all three carry outputs become 0. Reset wins over a tick in the same cycle.
- R2: When the tick is high at a clock edge, the seconds units digit steps up by one. After 9 it returns to 0.
- R3: The seconds tens digit steps up by one when the seconds units digit wraps from 9 to 0. It stays within 0 to 5.
- R4: A tick at seconds 59 sets the seconds to 00 and raises the minute carry for that one update.
- R5: The minute carry advances the minutes field, which counts 00 to 59 as units and tens digits. Its wrap from 59 to 00 raises the hour carry for that one update.
- R6: The hour carry advances the hours units digit. At 9 that digit returns to 0 and the hours tens digit steps up, so 09 becomes 10 and 19 becomes 20.
- R7: The hours field wraps from 23 to 00 with both digits cleared in the same update. That update raises the day carry, and the hours units digit never shows a value above 3 while the tens digit is 2.
- R8: A tick at 23:59:59 gives 00:00:00 after one update, with the minute, hour and day carries all high in that cycle.
- R9: Each carry output is high for exactly one cycle per wrap and is low in every other cycle.
- R10: In a cycle without a tick and without reset, all digits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| secTick | input | 1 | One-second advance strobe |
| secUnits | output | 4 | Seconds units digit, BCD |
| secTens | output | 4 | Seconds tens digit, BCD |
| minUnits | output | 4 | Minutes units digit, BCD |
| minTens | output | 4 | Minutes tens digit, BCD |
| hourUnits | output | 4 | Hours units digit, BCD |
| hourTens | output | 4 | Hours tens digit, BCD |
| minCarry | output | 1 | One-cycle pulse when seconds wrap |
| hourCarry | output | 1 | One-cycle pulse when minutes wrap |
| dayCarry | output | 1 | One-cycle pulse when hours wrap |

## Verification
The bench uses the default parameters: 4-bit digits, field limits 59, 59 and 23. With those limits a full day is 86,400 ticks. When the tick is held high every cycle, the bench drives the counter through a complete day, including the single update from 23:59:59 to 00:00:00. Earlier and later phases use sparse and alternating tick patterns, which exercise the hold behaviour. A reset arrives together with a tick to confirm that reset takes priority.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int SEC_U  = 0;
  localparam int SEC_T  = 1;
  localparam int MIN_U  = 2;
  localparam int MIN_T  = 3;
  localparam int HOUR_U = 4;
  localparam int HOUR_T = 5;

  typedef struct packed {
    logic [NUM_DIGITS-1:0] incEn;
    logic [NUM_DIGITS-1:0] clrEn;
    logic                  minCarry;
    logic                  hourCarry;
    logic                  dayCarry;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int DIGIT_W       = 4,
  parameter int UNITS_LAST    = 9,
  parameter int MS_TENS_LAST  = 5,
  parameter int HR_TENS_LAST  = 2,
  parameter int HR_UNITS_LAST = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              secTick,
  input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits,
  output todStrobe_t                         strobe
);
  localparam logic [DIGIT_W-1:0] U_LAST  = DIGIT_W'(UNITS_LAST);
  localparam logic [DIGIT_W-1:0] MS_LAST = DIGIT_W'(MS_TENS_LAST);
  localparam logic [DIGIT_W-1:0] HT_LAST = DIGIT_W'(HR_TENS_LAST);
  localparam logic [DIGIT_W-1:0] HU_LAST = DIGIT_W'(HR_UNITS_LAST);

  logic secUnitsWrap, secWrap;
  logic minUnitsWrap, minWrap;
  logic hourUnitsWrap, dayWrap;

  // seconds field: units then tens, carry ripples in the same cycle
  assign secUnitsWrap  = secTick && (digits[SEC_U] == U_LAST);
  assign secWrap       = secUnitsWrap && (digits[SEC_T] == MS_LAST);
  // minutes field driven by the seconds wrap
  assign minUnitsWrap  = secWrap && (digits[MIN_U] == U_LAST);
  assign minWrap       = minUnitsWrap && (digits[MIN_T] == MS_LAST);
  // hours field: the joint 23 detection overrides the per-digit wrap
  assign dayWrap       = minWrap && (digits[HOUR_T] == HT_LAST) && (digits[HOUR_U] == HU_LAST);
  assign hourUnitsWrap = minWrap && (digits[HOUR_U] == U_LAST);

  always_comb begin
    strobe = '0;
    strobe.incEn[SEC_U]  = secTick;
    strobe.clrEn[SEC_U]  = secUnitsWrap;
    strobe.incEn[SEC_T]  = secUnitsWrap;
    strobe.clrEn[SEC_T]  = secWrap;
    strobe.incEn[MIN_U]  = secWrap;
    strobe.clrEn[MIN_U]  = minUnitsWrap;
    strobe.incEn[MIN_T]  = minUnitsWrap;
    strobe.clrEn[MIN_T]  = minWrap;
    strobe.incEn[HOUR_U] = minWrap;
    strobe.clrEn[HOUR_U] = hourUnitsWrap || dayWrap;
    strobe.incEn[HOUR_T] = hourUnitsWrap;
    strobe.clrEn[HOUR_T] = dayWrap;
    strobe.minCarry      = secWrap;
    strobe.hourCarry     = minWrap;
    strobe.dayCarry      = dayWrap;
  end

  // a day wrap only arises through the whole chain below it (R8)
  assert_chain_order_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.dayCarry |-> (strobe.hourCarry && strobe.minCarry && secTick));

  // the hours tens digit never steps while it is at its last value (R7)
  assert_hour_tens_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (digits[HOUR_T] == HT_LAST) |-> !strobe.incEn[HOUR_T]);
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int DIGIT_W       = 4,
  parameter int UNITS_LAST    = 9,
  parameter int MS_TENS_LAST  = 5,
  parameter int HR_TENS_LAST  = 2,
  parameter int HR_UNITS_LAST = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  todStrobe_t                         strobe,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digitQ,
  output logic                              minCarryQ,
  output logic                              hourCarryQ,
  output logic                              dayCarryQ
);
  localparam logic [DIGIT_W-1:0] ONE = DIGIT_W'(1);

  genvar i;
  generate
    for (i = 0; i < NUM_DIGITS; i++) begin : g_digit
      always_ff @(posedge clk) begin
        if (rst)                  digitQ[i] <= '0;
        else if (strobe.clrEn[i]) digitQ[i] <= '0;
        else if (strobe.incEn[i]) digitQ[i] <= digitQ[i] + ONE;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      minCarryQ  <= 1'b0;
      hourCarryQ <= 1'b0;
      dayCarryQ  <= 1'b0;
    end else begin
      minCarryQ  <= strobe.minCarry;
      hourCarryQ <= strobe.hourCarry;
      dayCarryQ  <= strobe.dayCarry;
    end
  end

  assert_units_range_R2: assert property (@(posedge clk) disable iff (rst)
    (digitQ[SEC_U] <= DIGIT_W'(UNITS_LAST)) && (digitQ[MIN_U] <= DIGIT_W'(UNITS_LAST))
    && (digitQ[HOUR_U] <= DIGIT_W'(UNITS_LAST)));

  assert_tens_range_R3: assert property (@(posedge clk) disable iff (rst)
    (digitQ[SEC_T] <= DIGIT_W'(MS_TENS_LAST)) && (digitQ[MIN_T] <= DIGIT_W'(MS_TENS_LAST)));

  assert_hour_range_R7: assert property (@(posedge clk) disable iff (rst)
    (digitQ[HOUR_T] < DIGIT_W'(HR_TENS_LAST)) ||
    ((digitQ[HOUR_T] == DIGIT_W'(HR_TENS_LAST)) && (digitQ[HOUR_U] <= DIGIT_W'(HR_UNITS_LAST))));

  assert_min_carry_zero_R4: assert property (@(posedge clk) disable iff (rst)
    minCarryQ |-> (digitQ[SEC_U] == '0) && (digitQ[SEC_T] == '0));

  assert_day_carry_zero_R7: assert property (@(posedge clk) disable iff (rst)
    dayCarryQ |-> (digitQ[HOUR_U] == '0) && (digitQ[HOUR_T] == '0));

  assert_min_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    minCarryQ |=> !minCarryQ);

  assert_hour_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    hourCarryQ |=> !hourCarryQ);
endmodule

// File: rtl/tod_bcd_chain.sv
module tod_bcd_chain
  import tod_pkg::*;
#(
  parameter int DIGIT_W       = 4,
  parameter int UNITS_LAST    = 9,
  parameter int MS_TENS_LAST  = 5,
  parameter int HR_TENS_LAST  = 2,
  parameter int HR_UNITS_LAST = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               secTick,
  output logic [DIGIT_W-1:0] secUnits,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] minUnits,
  output logic [DIGIT_W-1:0] minTens,
  output logic [DIGIT_W-1:0] hourUnits,
  output logic [DIGIT_W-1:0] hourTens,
  output logic               minCarry,
  output logic               hourCarry,
  output logic               dayCarry
);
  todStrobe_t                         strobe;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

  tod_ctrl #(
    .DIGIT_W(DIGIT_W), .UNITS_LAST(UNITS_LAST), .MS_TENS_LAST(MS_TENS_LAST),
    .HR_TENS_LAST(HR_TENS_LAST), .HR_UNITS_LAST(HR_UNITS_LAST)
  ) uCtrl (
    .clk(clk), .rst(rst), .secTick(secTick), .digits(digits), .strobe(strobe)
  );

  tod_datapath #(
    .DIGIT_W(DIGIT_W), .UNITS_LAST(UNITS_LAST), .MS_TENS_LAST(MS_TENS_LAST),
    .HR_TENS_LAST(HR_TENS_LAST), .HR_UNITS_LAST(HR_UNITS_LAST)
  ) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .digitQ(digits),
    .minCarryQ(minCarry), .hourCarryQ(hourCarry), .dayCarryQ(dayCarry)
  );

  assign secUnits  = digits[SEC_U];
  assign secTens   = digits[SEC_T];
  assign minUnits  = digits[MIN_U];
  assign minTens   = digits[MIN_T];
  assign hourUnits = digits[HOUR_U];
  assign hourTens  = digits[HOUR_T];

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !secTick |=> $stable(digits));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (digits == '0) && !minCarry && !hourCarry && !dayCarry);
endmodule

// File: tb/sim_tod_bcd_chain.sv
`timescale 1ns/1ps
module sim_tod_bcd_chain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic secTick = 1'b0;
  logic [3:0] secUnits, secTens, minUnits, minTens, hourUnits, hourTens;
  logic minCarry, hourCarry, dayCarry;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit finished = 0;

  // behavioural reference state
  int  mSec = 0, mMin = 0, mHour = 0;
  bit  mMinC = 0, mHourC = 0, mDayC = 0;
  bit  mWasRst = 1;
  bit  lastTick = 0;
  logic [23:0] prevDigits = '0;
  bit  prevMinC = 0, prevHourC = 0, prevDayC = 0;

  always #2.5 clk = ~clk;

  tod_bcd_chain u0 (
    .clk(clk), .rst(rst), .secTick(secTick),
    .secUnits(secUnits), .secTens(secTens), .minUnits(minUnits), .minTens(minTens),
    .hourUnits(hourUnits), .hourTens(hourTens),
    .minCarry(minCarry), .hourCarry(hourCarry), .dayCarry(dayCarry)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    lastTick = secTick;
    mMinC = 0; mHourC = 0; mDayC = 0;
    if (rst) begin
      mSec = 0; mMin = 0; mHour = 0; mWasRst = 1;
    end else begin
      mWasRst = 0;
      if (secTick) begin
        mSec++;
        if (mSec == 60) begin
          mSec = 0; mMinC = 1; mMin++;
          if (mMin == 60) begin
            mMin = 0; mHourC = 1; mHour++;
            if (mHour == 24) begin mHour = 0; mDayC = 1; end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [23:0] curDigits;
      curDigits = {hourTens, hourUnits, minTens, minUnits, secTens, secUnits};
      if (mWasRst) begin
        check(int'(curDigits), 0, "R1 digits after reset");
        check(int'({minCarry, hourCarry, dayCarry}), 0, "R1 carries after reset");
      end else begin
        check(secUnits,  mSec % 10,  "R2 seconds units");
        check(secTens,   mSec / 10,  "R3 seconds tens");
        check(minUnits,  mMin % 10,  "R5 minutes units");
        check(minTens,   mMin / 10,  "R5 minutes tens");
        check(hourUnits, mHour % 10, "R6 hours units");
        check(hourTens,  mHour / 10, "R6 hours tens");
        check(minCarry,  mMinC,      "R4 minute carry");
        check(hourCarry, mHourC,     "R5 hour carry");
        check(dayCarry,  mDayC,      "R7 day carry");
        if (mDayC) begin
          check(int'(curDigits), 0, "R8 rollover digits");
          check(int'({minCarry, hourCarry, dayCarry}), 7, "R8 rollover carries");
        end
        if (!lastTick) check(int'(curDigits), int'(prevDigits), "R10 hold without tick");
        if (prevMinC)  check(minCarry,  0, "R9 minute carry width");
        if (prevHourC) check(hourCarry, 0, "R9 hour carry width");
        if (prevDayC)  check(dayCarry,  0, "R9 day carry width");
      end
      prevDigits = curDigits;
      prevMinC = minCarry; prevHourC = hourCarry; prevDayC = dayCarry;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checking = 1;
    rst = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      secTick = (i % 3 == 0);
      @(negedge clk);
    end
    secTick = 1;
    repeat (86500) @(negedge clk);
    secTick = 0;
    repeat (4) @(negedge clk);
    secTick = 1; rst = 1;
    @(negedge clk);
    rst = 0; secTick = 0;
    for (int i = 0; i < 140; i++) begin
      secTick = (i % 2 == 0);
      @(negedge clk);
    end
    secTick = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule